// File: doc/BRIEF.md
# Integer ALU with Flag Generation

This block is the single-cycle integer execution unit for a 32-bit core. It handles the register and immediate forms of addition, the two forms of compare, and bitwise AND. For each operation it produces a result, a register write enable, the carry, overflow, sign and zero condition flags, and a mask that tells the status logic which of those flags the operation updates. The upstream decoder supplies the 6-bit operation field, the two register operands, and a short 5-bit and a long 16-bit immediate. The datapath selects the immediate and extends it as each operation requires.

An operation is presented with `issue` high for one clock. Its result appears on the registered outputs after that clock edge, with `done` high, so every operation completes in one clock. A small state machine has two states. `ST_IDLE` means no result is being presented. `ST_RESULT` means the outputs carry the operation issued on the previous edge. The transitions are:

- `ST_IDLE` goes to `ST_RESULT` on issue.
- `ST_RESULT` stays in `ST_RESULT` on a back-to-back issue.
- `ST_RESULT` returns to `ST_IDLE` when no issue is present.

Compare computes a subtraction and updates flags, but never requests a register write. The consumer must apply the mask, so that AND leaves the carry flag as it was.

Top module: `int_alu_flags`

## Requirements
- R1: `done` is high in the cycle after every edge that samples `issue` high (state `ST_RESULT`) and low otherwise (state `ST_IDLE`). Back-to-back issues give back-to-back results. While `done` is low, `wr_en` is 0 and `flag_mask` is 0.
- R2: Op field 6'b001110 (register add) yields `result = src2 + src1`, `wr_en = 1` and `flag_mask = 4'b1111`.
- R3: Op field 6'b010010 (short-immediate add) yields `result = src2 + sign-extended imm5`, `wr_en = 1` and `flag_mask = 4'b1111`.
- R4: Op field 6'b110000 (long-immediate add) yields `result = src1 + sign-extended imm16`, `wr_en = 1` and `flag_mask = 4'b1111`.
- R5: Op field 6'b001010 (register AND) yields `src2 & src1`. Op field 6'b110110 (long-immediate AND) yields `src1 & zero-extended imm16`. Both give `wr_en = 1` and `flag_mask = 4'b0111`.
- R6: Op fields 6'b001111 (register compare) and 6'b010011 (short-immediate compare) compute `src2 - src1` or `src2 - sign-extended imm5`. The difference appears on `result`, with `wr_en = 0` and `flag_mask = 4'b1111`.
- R7: `flag_cy` is the carry out of bit 31 for additions. For compares it is the borrow, which is 1 when the unsigned minuend is below the subtrahend. For AND it is 0 and is excluded from the mask.
- R8: `flag_ov` is 1 when the signed add or subtract result falls outside the 32-bit two's-complement range. For AND it is forced to 0.
- R9: `flag_s` equals `result[31]`, and `flag_z` is 1 exactly when all 32 result bits are 0.
- R10: Any other op field still produces a `done` pulse, with `wr_en = 0` and `flag_mask = 0`.
- R11: While reset is active, `done`, `wr_en`, `flag_mask`, `result` and all four flags are 0.

Mask bit positions: bit 3 carry, bit 2 overflow, bit 1 sign, bit 0 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Operation presented this cycle |
| op_code | input | 6 | Operation field of the instruction |
| src1 | input | 32 | First register operand |
| src2 | input | 32 | Second register operand, also the destination's old value |
| imm_s | input | 5 | Short immediate |
| imm_l | input | 16 | Long immediate |
| done | output | 1 | Result outputs are valid |
| result | output | 32 | Operation result, or difference for compare |
| wr_en | output | 1 | Destination register write request |
| flag_cy | output | 1 | Carry / borrow flag |
| flag_ov | output | 1 | Signed overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_mask | output | 4 | Flags this operation updates (3 CY, 2 OV, 1 S, 0 Z) |

## Verification
Each adder form is driven with small operands, then with operands that cross the signed limit, and then with operands that wrap the unsigned range to zero. These patterns separate the carry from the overflow and expose a wrong operand choice between `src1` and `src2`. The immediates are given values with their top bit set, which distinguishes sign extension from zero extension, and so checks that the long AND immediate is zero-extended while the add immediates are not. Compares are run with equal operands, with a smaller minuend and across the signed boundary, to separate the borrow sense, the zero flag and overflow. Back-to-back issues, an unknown op field and idle cycles exercise the state transitions.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int OPC_W = 6;

    localparam int FLG_CY = 3;
    localparam int FLG_OV = 2;
    localparam int FLG_S  = 1;
    localparam int FLG_Z  = 0;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD_R   = 6'b001110,
        OPC_CMP_R   = 6'b001111,
        OPC_AND_R   = 6'b001010,
        OPC_ADD_I5  = 6'b010010,
        OPC_CMP_I5  = 6'b010011,
        OPC_ADD_I16 = 6'b110000,
        OPC_AND_I16 = 6'b110110
    } opc_e;

    typedef enum logic [1:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_NONE
    } fn_e;

    typedef enum logic [1:0] {
        BSEL_REG1,
        BSEL_IMM5S,
        BSEL_IMM16S,
        BSEL_IMM16Z
    } bsel_e;

    typedef struct packed {
        fn_e        fn;
        logic       a_is_reg1;
        bsel_e      bsel;
        logic       wr;
        logic [3:0] mask;
    } ctl_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } alu_state_e;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_flags_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    output ctl_t             ctl
);

    localparam logic [3:0] MASK_ARITH = 4'b1111;
    localparam logic [3:0] MASK_LOGIC = 4'b0111;

    always_comb begin
        ctl = '{fn: FN_NONE, a_is_reg1: 1'b0, bsel: BSEL_REG1, wr: 1'b0, mask: 4'b0000};
        case (op_code)
            OPC_ADD_R: begin
                ctl.fn   = FN_ADD;
                ctl.wr   = 1'b1;
                ctl.mask = MASK_ARITH;
            end
            OPC_ADD_I5: begin
                ctl.fn   = FN_ADD;
                ctl.bsel = BSEL_IMM5S;
                ctl.wr   = 1'b1;
                ctl.mask = MASK_ARITH;
            end
            OPC_ADD_I16: begin
                ctl.fn        = FN_ADD;
                ctl.a_is_reg1 = 1'b1;
                ctl.bsel      = BSEL_IMM16S;
                ctl.wr        = 1'b1;
                ctl.mask      = MASK_ARITH;
            end
            OPC_CMP_R: begin
                ctl.fn   = FN_SUB;
                ctl.mask = MASK_ARITH;
            end
            OPC_CMP_I5: begin
                ctl.fn   = FN_SUB;
                ctl.bsel = BSEL_IMM5S;
                ctl.mask = MASK_ARITH;
            end
            OPC_AND_R: begin
                ctl.fn   = FN_AND;
                ctl.wr   = 1'b1;
                ctl.mask = MASK_LOGIC;
            end
            OPC_AND_I16: begin
                ctl.fn        = FN_AND;
                ctl.a_is_reg1 = 1'b1;
                ctl.bsel      = BSEL_IMM16Z;
                ctl.wr        = 1'b1;
                ctl.mask      = MASK_LOGIC;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_operand.sv
module alu_operand
    import alu_flags_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_S_W = 5,
    parameter int IMM_L_W = 16
) (
    input  logic               a_is_reg1,
    input  bsel_e              bsel,
    input  logic [DATA_W-1:0]  src1,
    input  logic [DATA_W-1:0]  src2,
    input  logic [IMM_S_W-1:0] imm_s,
    input  logic [IMM_L_W-1:0] imm_l,
    output logic [DATA_W-1:0]  opa,
    output logic [DATA_W-1:0]  opb
);

    localparam int PAD_S = DATA_W - IMM_S_W;
    localparam int PAD_L = DATA_W - IMM_L_W;

    logic [DATA_W-1:0] imm_s_sx;
    logic [DATA_W-1:0] imm_l_sx;
    logic [DATA_W-1:0] imm_l_zx;

    assign imm_s_sx = {{PAD_S{imm_s[IMM_S_W-1]}}, imm_s};
    assign imm_l_sx = {{PAD_L{imm_l[IMM_L_W-1]}}, imm_l};
    assign imm_l_zx = {{PAD_L{1'b0}}, imm_l};

    assign opa = a_is_reg1 ? src1 : src2;

    always_comb begin
        unique case (bsel)
            BSEL_REG1:   opb = src1;
            BSEL_IMM5S:  opb = imm_s_sx;
            BSEL_IMM16S: opb = imm_l_sx;
            BSEL_IMM16Z: opb = imm_l_zx;
            default:     opb = src1;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    assign b_eff = sub ? ~b : b;
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    assign sum   = wide[MSB:0];
    // carry out for add, inverted to a borrow for subtract
    assign carry = sub ? ~wide[DATA_W] : wide[DATA_W];
    assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fn_e               fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] sum,
    input  logic              carry,
    input  logic              ovf,
    output logic [DATA_W-1:0] res,
    output logic              cy,
    output logic              ov,
    output logic              s,
    output logic              z
);

    logic is_logic;

    assign is_logic = (fn == FN_AND);
    assign res      = is_logic ? (a & b) : sum;
    assign cy       = is_logic ? 1'b0 : carry;
    assign ov       = is_logic ? 1'b0 : ovf;
    assign s        = res[DATA_W-1];
    assign z        = ~|res;

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
    import alu_flags_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_S_W = 5,
    parameter int IMM_L_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [OPC_W-1:0]   op_code,
    input  logic [DATA_W-1:0]  src1,
    input  logic [DATA_W-1:0]  src2,
    input  logic [IMM_S_W-1:0] imm_s,
    input  logic [IMM_L_W-1:0] imm_l,
    output logic               done,
    output logic [DATA_W-1:0]  result,
    output logic               wr_en,
    output logic               flag_cy,
    output logic               flag_ov,
    output logic               flag_s,
    output logic               flag_z,
    output logic [3:0]         flag_mask
);

    ctl_t              ctl;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic              ovf;
    logic [DATA_W-1:0] res_d;
    logic              cy_d;
    logic              ov_d;
    logic              s_d;
    logic              z_d;

    alu_state_e        state_q;
    alu_state_e        state_d;
    logic [DATA_W-1:0] result_q;
    logic              wr_q;
    logic              cy_q;
    logic              ov_q;
    logic              s_q;
    logic              z_q;
    logic [3:0]        mask_q;

    alu_decode u_decode (
        .op_code (op_code),
        .ctl     (ctl)
    );

    alu_operand #(
        .DATA_W  (DATA_W),
        .IMM_S_W (IMM_S_W),
        .IMM_L_W (IMM_L_W)
    ) u_operand (
        .a_is_reg1 (ctl.a_is_reg1),
        .bsel      (ctl.bsel),
        .src1      (src1),
        .src2      (src2),
        .imm_s     (imm_s),
        .imm_l     (imm_l),
        .opa       (opa),
        .opb       (opb)
    );

    alu_addsub #(
        .DATA_W (DATA_W)
    ) u_addsub (
        .sub   (ctl.fn == FN_SUB),
        .a     (opa),
        .b     (opb),
        .sum   (sum),
        .carry (carry),
        .ovf   (ovf)
    );

    alu_flag_gen #(
        .DATA_W (DATA_W)
    ) u_flags (
        .fn    (ctl.fn),
        .a     (opa),
        .b     (opb),
        .sum   (sum),
        .carry (carry),
        .ovf   (ovf),
        .res   (res_d),
        .cy    (cy_d),
        .ov    (ov_d),
        .s     (s_d),
        .z     (z_d)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = issue ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = issue ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered result stage, loaded on each issue
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            wr_q     <= 1'b0;
            cy_q     <= 1'b0;
            ov_q     <= 1'b0;
            s_q      <= 1'b0;
            z_q      <= 1'b0;
            mask_q   <= 4'b0000;
        end else if (issue) begin
            result_q <= res_d;
            wr_q     <= ctl.wr;
            cy_q     <= cy_d;
            ov_q     <= ov_d;
            s_q      <= s_d;
            z_q      <= z_d;
            mask_q   <= ctl.mask;
        end
    end

    assign done      = (state_q == ST_RESULT);
    assign result    = result_q;
    assign wr_en     = done & wr_q;
    assign flag_cy   = cy_q;
    assign flag_ov   = ov_q;
    assign flag_s    = s_q;
    assign flag_z    = z_q;
    assign flag_mask = done ? mask_q : 4'b0000;

endmodule

// File: rtl/int_alu_flags_checker.sv
module int_alu_flags_checker
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic [OPC_W-1:0]  op_code,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              flag_cy,
    input logic              flag_ov,
    input logic              flag_s,
    input logic              flag_z,
    input logic [3:0]        flag_mask
);

    logic             prev_issue_q;
    logic [OPC_W-1:0] prev_op_q;
    logic             prev_cmp;
    logic             prev_and;
    logic             prev_known;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_issue_q <= 1'b0;
            prev_op_q    <= '0;
        end else begin
            prev_issue_q <= issue;
            prev_op_q    <= op_code;
        end
    end

    assign prev_cmp   = (prev_op_q == OPC_CMP_R) || (prev_op_q == OPC_CMP_I5);
    assign prev_and   = (prev_op_q == OPC_AND_R) || (prev_op_q == OPC_AND_I16);
    assign prev_known = prev_cmp || prev_and || (prev_op_q == OPC_ADD_R)
                     || (prev_op_q == OPC_ADD_I5) || (prev_op_q == OPC_ADD_I16);

    assert_done_follows_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done == prev_issue_q);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!wr_en && flag_mask == 4'b0000));

    assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && prev_cmp) |-> (!wr_en && flag_mask == 4'b1111));

    assert_and_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && prev_and) |-> (!flag_ov && !flag_cy && flag_mask == 4'b0111 && wr_en));

    assert_sign_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_s == result[DATA_W-1]));

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (result == '0)));

    assert_unknown_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !prev_known) |-> (!wr_en && flag_mask == 4'b0000));

endmodule

bind int_alu_flags int_alu_flags_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .op_code   (op_code),
    .done      (done),
    .result    (result),
    .wr_en     (wr_en),
    .flag_cy   (flag_cy),
    .flag_ov   (flag_ov),
    .flag_s    (flag_s),
    .flag_z    (flag_z),
    .flag_mask (flag_mask)
);

// File: tb/int_alu_flags_bench.sv
`timescale 1ns/1ps
module int_alu_flags_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [5:0]  op_code = 6'b0;
    logic [31:0] src1 = 32'b0;
    logic [31:0] src2 = 32'b0;
    logic [4:0]  imm_s = 5'b0;
    logic [15:0] imm_l = 16'b0;
    logic        done;
    logic [31:0] result;
    logic        wr_en;
    logic        flag_cy;
    logic        flag_ov;
    logic        flag_s;
    logic        flag_z;
    logic [3:0]  flag_mask;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    int_alu_flags u_int_alu_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .op_code   (op_code),
        .src1      (src1),
        .src2      (src2),
        .imm_s     (imm_s),
        .imm_l     (imm_l),
        .done      (done),
        .result    (result),
        .wr_en     (wr_en),
        .flag_cy   (flag_cy),
        .flag_ov   (flag_ov),
        .flag_s    (flag_s),
        .flag_z    (flag_z),
        .flag_mask (flag_mask)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // independent reference for one operation
    task automatic model(input logic [5:0] op, input logic [31:0] s1, input logic [31:0] s2,
                         input logic [4:0] i5, input logic [15:0] i16,
                         output logic [31:0] r, output logic wr, output logic cy,
                         output logic ov, output logic [3:0] m);
        logic [31:0] a;
        logic [31:0] b;
        logic [32:0] u;
        longint      sr;
        int          kind;
        a = s2; b = s1; kind = 0;
        case (op)
            6'b001110: begin a = s2; b = s1; kind = 1; end
            6'b010010: begin a = s2; b = {{27{i5[4]}}, i5}; kind = 1; end
            6'b110000: begin a = s1; b = {{16{i16[15]}}, i16}; kind = 1; end
            6'b001111: begin a = s2; b = s1; kind = 2; end
            6'b010011: begin a = s2; b = {{27{i5[4]}}, i5}; kind = 2; end
            6'b001010: begin a = s2; b = s1; kind = 3; end
            6'b110110: begin a = s1; b = {16'h0000, i16}; kind = 3; end
            default:   kind = 0;
        endcase
        r = 32'h0; wr = 1'b0; cy = 1'b0; ov = 1'b0; m = 4'b0000;
        if (kind == 1) begin
            u  = {1'b0, a} + {1'b0, b};
            r  = u[31:0];
            cy = u[32];
            sr = longint'($signed(a)) + longint'($signed(b));
            ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            wr = 1'b1; m = 4'b1111;
        end else if (kind == 2) begin
            r  = a - b;
            cy = (a < b);
            sr = longint'($signed(a)) - longint'($signed(b));
            ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            wr = 1'b0; m = 4'b1111;
        end else if (kind == 3) begin
            r  = a & b;
            wr = 1'b1; m = 4'b0111;
        end
    endtask

    task automatic verify(input string tag, input logic [5:0] op, input logic [31:0] s1,
                          input logic [31:0] s2, input logic [4:0] i5, input logic [15:0] i16);
        logic [31:0] r;
        logic        wr;
        logic        cy;
        logic        ov;
        logic [3:0]  m;
        model(op, s1, s2, i5, i16, r, wr, cy, ov, m);
        chk(tag, "done", {31'b0, done}, 32'd1);
        chk(tag, "wr_en", {31'b0, wr_en}, {31'b0, wr});
        chk(tag, "mask", {28'b0, flag_mask}, {28'b0, m});
        if (m != 4'b0000) begin
            chk(tag, "result", result, r);
            chk(tag, "cy", {31'b0, flag_cy}, {31'b0, cy});
            chk(tag, "ov", {31'b0, flag_ov}, {31'b0, ov});
            chk(tag, "s", {31'b0, flag_s}, {31'b0, r[31]});
            chk(tag, "z", {31'b0, flag_z}, {31'b0, (r == 32'h0)});
        end
    endtask

    task automatic drive(input logic [5:0] op, input logic [31:0] s1, input logic [31:0] s2,
                         input logic [4:0] i5, input logic [15:0] i16);
        issue = 1'b1; op_code = op; src1 = s1; src2 = s2; imm_s = i5; imm_l = i16;
    endtask

    task automatic run_one(input string tag, input logic [5:0] op, input logic [31:0] s1,
                           input logic [31:0] s2, input logic [4:0] i5, input logic [15:0] i16);
        @(negedge clk);
        drive(op, s1, s2, i5, i16);
        @(posedge clk);
        @(negedge clk);
        issue = 1'b0;
        verify(tag, op, s1, s2, i5, i16);
    endtask

    task automatic test_reset();
        #5;
        chk("R11", "done", {31'b0, done}, 32'd0);
        chk("R11", "wr_en", {31'b0, wr_en}, 32'd0);
        chk("R11", "mask", {28'b0, flag_mask}, 32'd0);
        chk("R11", "result", result, 32'd0);
        chk("R11", "flags", {28'b0, flag_cy, flag_ov, flag_s, flag_z}, 32'd0);
    endtask

    task automatic test_add_reg();
        run_one("R2", 6'b001110, 32'd7, 32'd5, 5'd0, 16'd0);
        run_one("R8_add_ovf", 6'b001110, 32'd1, 32'h7fffffff, 5'd0, 16'd0);
        run_one("R7_add_carry", 6'b001110, 32'd1, 32'hffffffff, 5'd0, 16'd0);
        run_one("R2_order", 6'b001110, 32'h80000000, 32'h80000000, 5'd0, 16'd0);
    endtask

    task automatic test_add_imm5();
        run_one("R3_neg", 6'b010010, 32'hdeadbeef, 32'd10, 5'b11111, 16'd0);
        run_one("R3_pos", 6'b010010, 32'hdeadbeef, 32'd10, 5'b01111, 16'd0);
    endtask

    task automatic test_add_imm16();
        run_one("R4_neg", 6'b110000, 32'h00001000, 32'h12345678, 5'd0, 16'h8000);
        run_one("R4_pos", 6'b110000, 32'hfffffffe, 32'h0, 5'd0, 16'h0002);
    endtask

    task automatic test_and();
        run_one("R5_reg", 6'b001010, 32'hff00ff00, 32'hf0f0f0f0, 5'd0, 16'd0);
        run_one("R5_imm_zext", 6'b110110, 32'hffffffff, 32'h0, 5'd0, 16'h8001);
        run_one("R9_and_zero", 6'b110110, 32'hffff0000, 32'h0, 5'd0, 16'hffff);
    endtask

    task automatic test_cmp();
        run_one("R6_equal", 6'b001111, 32'd5, 32'd5, 5'd0, 16'd0);
        run_one("R7_borrow", 6'b001111, 32'd5, 32'd3, 5'd0, 16'd0);
        run_one("R8_cmp_ovf", 6'b001111, 32'd1, 32'h80000000, 5'd0, 16'd0);
        run_one("R6_imm5", 6'b010011, 32'd0, 32'd0, 5'b10000, 16'd0);
    endtask

    task automatic test_unknown();
        run_one("R10", 6'b000000, 32'd1, 32'd2, 5'd3, 16'd4);
        run_one("R10_b", 6'b111111, 32'd1, 32'd2, 5'd3, 16'd4);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        drive(6'b001110, 32'd100, 32'd23, 5'd0, 16'd0);
        @(posedge clk);
        @(negedge clk);
        verify("R1_first", 6'b001110, 32'd100, 32'd23, 5'd0, 16'd0);
        drive(6'b001111, 32'd9, 32'd9, 5'd0, 16'd0);
        @(posedge clk);
        @(negedge clk);
        issue = 1'b0;
        verify("R1_second", 6'b001111, 32'd9, 32'd9, 5'd0, 16'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R1_idle", "done", {31'b0, done}, 32'd0);
        chk("R1_idle", "wr_en", {31'b0, wr_en}, 32'd0);
        chk("R1_idle", "mask", {28'b0, flag_mask}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_add_reg();
        test_add_imm5();
        test_add_imm16();
        test_and();
        test_cmp();
        test_unknown();
        test_back_to_back();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule